// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns a stream of parallel audio samples into a two-channel serial bit stream on a single data pin, together with the left/right word clock that frames it. The serial bit clock is an input: all state advances on its falling edge, so a receiver can sample data and word clock on the rising edge. The word clock is produced internally by counting bit clocks, so each channel slot lasts a programmable number of bit clocks.

Static settings choose the sample length, the slot length, which level of the word clock marks the right channel, which channel is sent first after enable, and whether the first data bit lines up with the word-clock edge (left-justified) or follows it by one bit clock (I2S-style). Samples arrive over a valid/ready handshake, one per channel slot, and go out in arrival order. If a slot starts with no fresh sample, the previous sample of that channel is repeated and a sticky underflow flag is raised.

Settings are captured when the block starts and frozen while it runs. A setting whose slot is shorter than the sample, or whose sample length is below the minimum, is flagged and the block stays idle.

Top module: `stereo_ser_tx`

## Requirements
- R1: While running, the word clock holds its level for exactly `cfg_div`+1 bit clocks and then changes, giving a full period of 2×(`cfg_div`+1) bit clocks.
- R2: With `cfg_pol` = 0 the word clock is 1 during a right-channel slot and 0 during a left-channel slot; with `cfg_pol` = 1 both levels are swapped. While idle the word clock sits at the left-channel level.
- R3: The first slot after enable carries the left channel when `cfg_first_right` = 0 and the right channel when it is 1; slots then alternate.
- R4: A sample uses `in_data[cfg_wlen:0]` (`cfg_wlen`+1 bits) and is sent most significant bit first: with no delay, bit b appears at slot position `cfg_wlen`−b, position 0 being the bit clock at which the word clock changes.
- R5: With `cfg_delay` = 1 every data bit is sent one bit clock later than with `cfg_delay` = 0; a bit that thus falls past the end of a slot appears at position 0 of the next slot, and the very first position after enable carries 0.
- R6: Every position that carries no data bit drives 0, and the data pin is 0 while the block is idle.
- R7: When a slot starts with the holding buffer empty, the last sample sent in that channel is sent again (0 if none since reset) and `underflow` becomes 1 at that same falling edge.
- R8: `underflow` stays 1 until a falling edge sees `uf_clr` = 1 with no new underflow; that edge clears it.
- R9: `cfg_error` is 1 when `cfg_wlen` < 2 or `cfg_div` < `cfg_wlen`; while it is 1 the block does not start even with `enable` = 1.
- R10: Changes to any `cfg_*` input while running have no effect on the serial output until the block has been disabled.
- R11: `in_ready` is 1 exactly when the one-entry holding buffer is empty (and out of reset); a falling edge with `in_valid` and `in_ready` both 1 takes one sample, and samples fill slots in the order taken.
- R12: After reset `sdata` = 0, `underflow` = 0 and `in_ready` = 1; the first slot begins at the first falling edge that sees `enable` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released after two falling edges |
| enable | input | 1 | Run request; low returns the block to idle |
| cfg_wlen | input | 5 | Sample length minus one (valid 2..31) |
| cfg_div | input | DIV_W (8) | Slot length minus one, in bit clocks |
| cfg_pol | input | 1 | Word-clock polarity select |
| cfg_first_right | input | 1 | 1: right channel first after enable |
| cfg_delay | input | 1 | 1: data lags the word-clock edge by one bit clock |
| in_data | input | DATA_W (32) | Sample, right-aligned |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Holding buffer empty |
| uf_clr | input | 1 | Write-one clear of the underflow flag |
| sdata | output | 1 | Serial data |
| lrclk | output | 1 | Left/right word clock |
| underflow | output | 1 | Sticky underflow flag |
| cfg_error | output | 1 | Active settings are invalid |

## Verification
Every output is a register on the falling edge, so a stimulus applied before falling edge n shows its effect from that edge on: slot position p of a run is visible after the (p+1)-th falling edge with `enable` high, the underflow flag rises at the edge that starts the starved slot, and a clear shows one edge after `uf_clr` is seen. The bench changes inputs and reads outputs only at rising edges, half a period from the active edge, and indexes its expected word-clock and data values by slot position counted from the enabling edge. The feeder counts a sample as taken only when valid and ready were both high across the falling edge it straddled, so the expected sample for each slot follows arrival order.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

  function automatic chan_e other_chan(chan_e c);
    return (c == CH_LEFT) ? CH_RIGHT : CH_LEFT;
  endfunction
endpackage

// File: rtl/sat_frame_timer.sv
module sat_frame_timer
  import sat_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div,
  input  logic             first_right,
  output logic             run,
  output chan_e            chan,
  output logic             slot_start,
  output logic [DIV_W-1:0] cnt_nxt,
  output chan_e            chan_nxt
);
  logic [DIV_W-1:0] cnt_q;
  logic             run_nxt;

  always_comb begin
    slot_start = go && (!run || (cnt_q == div));
    run_nxt    = run;
    cnt_nxt    = cnt_q;
    chan_nxt   = chan;
    if (!go) begin
      run_nxt  = 1'b0;
      cnt_nxt  = '0;
      chan_nxt = CH_LEFT;
    end else if (slot_start) begin
      run_nxt  = 1'b1;
      cnt_nxt  = '0;
      chan_nxt = run ? other_chan(chan) : (first_right ? CH_RIGHT : CH_LEFT);
    end else begin
      cnt_nxt  = cnt_q + 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt_q <= '0;
      chan  <= CH_LEFT;
    end else begin
      run   <= run_nxt;
      cnt_q <= cnt_nxt;
      chan  <= chan_nxt;
    end
  end

  // R1: channel holds inside a slot and changes at its end
  a_r1_slot_hold: assert property (@(negedge clk) disable iff (!rst_n)
    (run && go && cnt_q != div) |=> (chan == $past(chan)));
  a_r1_slot_flip: assert property (@(negedge clk) disable iff (!rst_n)
    (run && go && cnt_q == div) |=> (chan != $past(chan)));
endmodule

// File: rtl/sat_word_buf.sv
module sat_word_buf
  import sat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  input  chan_e             take_chan,
  input  logic              uf_clr,
  output logic [DATA_W-1:0] word,
  output logic              underflow
);
  logic [DATA_W-1:0] hold_q;
  logic              full_q, full_nxt, accept, uf_nxt;
  logic [DATA_W-1:0] last_q [2];
  logic              tsel;

  assign in_ready = rst_n && !full_q;
  assign accept   = in_valid && !full_q;
  assign tsel     = (take_chan == CH_RIGHT);
  assign word     = full_q ? hold_q : last_q[tsel];

  always_comb begin
    full_nxt = full_q;
    if (take && full_q) full_nxt = 1'b0;
    else if (accept)    full_nxt = 1'b1;
    uf_nxt = underflow;
    if (take && !full_q) uf_nxt = 1'b1;
    else if (uf_clr)     uf_nxt = 1'b0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      full_q    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (accept) hold_q <= in_data;
      full_q    <= full_nxt;
      underflow <= uf_nxt;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_last
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)                                 last_q[c] <= '0;
      else if (take && full_q && (tsel == c[0]))  last_q[c] <= hold_q;
    end
  end

  // R8: flag is sticky without a clear request
  a_r8_sticky: assert property (@(negedge clk) disable iff (!rst_n)
    (underflow && !uf_clr) |=> underflow);
  // R11: a taken sample occupies the buffer
  a_r11_fill: assert property (@(negedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !take) |=> !in_ready);
  // R7: a starved slot start raises the flag
  a_r7_starve: assert property (@(negedge clk) disable iff (!rst_n)
    (take && in_ready) |=> underflow);
endmodule

// File: rtl/sat_serializer.sv
module sat_serializer #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int WL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              slot_start,
  input  logic [DATA_W-1:0] sel_word,
  input  logic [DIV_W-1:0]  cnt_nxt,
  input  logic [WL_W-1:0]   wlen,
  input  logic              delay,
  output logic              sdata
);
  logic [DATA_W-1:0] cur_q, word_nxt;
  logic              b0_q, bit_nxt, sd_nxt;

  assign word_nxt = slot_start ? sel_word : cur_q;

  always_comb begin
    bit_nxt = 1'b0;
    if (32'(cnt_nxt) <= 32'(wlen))
      bit_nxt = word_nxt[WL_W'(wlen - WL_W'(cnt_nxt))];
    if (!go)        sd_nxt = 1'b0;
    else if (delay) sd_nxt = b0_q;
    else            sd_nxt = bit_nxt;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      b0_q  <= 1'b0;
      sdata <= 1'b0;
    end else begin
      if (slot_start) cur_q <= sel_word;
      b0_q  <= go && bit_nxt;
      sdata <= sd_nxt;
    end
  end

  // R6: idle drives zero
  a_r6_idle_zero: assert property (@(negedge clk) disable iff (!rst_n)
    !go |=> !sdata);
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int WL_W  = $clog2(DATA_W)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [WL_W-1:0]   cfg_wlen,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_pol,
  input  logic              cfg_first_right,
  input  logic              cfg_delay,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              uf_clr,
  output logic              sdata,
  output logic              lrclk,
  output logic              underflow,
  output logic              cfg_error
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              run, slot_start, go;
  chan_e             chan, chan_nxt;
  logic [DIV_W-1:0]  cnt_nxt;
  logic [DATA_W-1:0] sel_word;

  logic [WL_W-1:0]   wlen_q, wlen_e;
  logic [DIV_W-1:0]  div_q, div_e;
  logic              pol_q, pol_e, first_q, first_e, dly_q, dly_e;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // settings snapshot, refreshed only while idle
  always_ff @(negedge sclk or negedge rst_s) begin
    if (!rst_s) begin
      wlen_q  <= '0;
      div_q   <= '0;
      pol_q   <= 1'b0;
      first_q <= 1'b0;
      dly_q   <= 1'b0;
    end else if (!run) begin
      wlen_q  <= cfg_wlen;
      div_q   <= cfg_div;
      pol_q   <= cfg_pol;
      first_q <= cfg_first_right;
      dly_q   <= cfg_delay;
    end
  end

  assign wlen_e  = run ? wlen_q  : cfg_wlen;
  assign div_e   = run ? div_q   : cfg_div;
  assign pol_e   = run ? pol_q   : cfg_pol;
  assign first_e = run ? first_q : cfg_first_right;
  assign dly_e   = run ? dly_q   : cfg_delay;

  assign cfg_error = (wlen_e < WL_W'(2)) || (32'(div_e) < 32'(wlen_e));
  assign go        = enable && !cfg_error;
  assign lrclk     = (chan == CH_RIGHT) ^ pol_e;

  sat_frame_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(sclk), .rst_n(rst_s), .go(go), .div(div_e), .first_right(first_e),
    .run(run), .chan(chan), .slot_start(slot_start),
    .cnt_nxt(cnt_nxt), .chan_nxt(chan_nxt)
  );

  sat_word_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(sclk), .rst_n(rst_s), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .take(slot_start), .take_chan(chan_nxt),
    .uf_clr(uf_clr), .word(sel_word), .underflow(underflow)
  );

  sat_serializer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ser (
    .clk(sclk), .rst_n(rst_s), .go(go), .slot_start(slot_start),
    .sel_word(sel_word), .cnt_nxt(cnt_nxt), .wlen(wlen_e), .delay(dly_e),
    .sdata(sdata)
  );

  // R9: invalid settings keep the block idle
  a_r9_no_start: assert property (@(negedge sclk) disable iff (!rst_s)
    (cfg_error && !run) |=> !run);
  // R12: the first enabled edge starts a slot
  a_r12_start: assert property (@(negedge sclk) disable iff (!rst_s)
    (enable && !cfg_error && !run) |=> run);
endmodule

// File: tb/stereo_ser_tx_tb.sv
`timescale 1ns/1ps
module stereo_ser_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n, enable, cfg_pol, cfg_first_right, cfg_delay, uf_clr;
  logic [4:0]  cfg_wlen;
  logic [7:0]  cfg_div;
  logic [31:0] in_data;
  logic        in_valid, in_ready, sdata, lrclk, underflow, cfg_error;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stereo_ser_tx u_dut (
    .sclk(clk), .rst_n(rst_n), .enable(enable), .cfg_wlen(cfg_wlen),
    .cfg_div(cfg_div), .cfg_pol(cfg_pol), .cfg_first_right(cfg_first_right),
    .cfg_delay(cfg_delay), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .uf_clr(uf_clr), .sdata(sdata), .lrclk(lrclk),
    .underflow(underflow), .cfg_error(cfg_error)
  );

  function automatic logic [31:0] pat(int row, int n);
    return (32'h9E3779B9 * 32'(row * 16 + n + 1)) ^ 32'h5A5A0F0F;
  endfunction

  // feeder: counts a sample as taken when valid and ready spanned a falling edge
  bit feed_rst = 1;
  int feed_limit = 0, feed_row = 0;
  int idx;
  bit v_last, r_last;
  always @(posedge clk) begin
    if (feed_rst) begin
      idx = 0; v_last = 0; r_last = 0;
      in_valid <= 1'b0; in_data <= '0;
    end else begin
      if (v_last && r_last) idx = idx + 1;
      v_last = (idx < feed_limit);
      r_last = in_ready;
      in_valid <= v_last;
      in_data  <= pat(feed_row, idx);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_sd(int p, int row, int wl, int dv, int dl);
    int q, s, k;
    logic [31:0] w;
    if (dl != 0) begin
      if (p == 0) return 1'b0;
      q = p - 1;
    end else q = p;
    s = q / (dv + 1); k = q % (dv + 1);
    w = pat(row, s);
    if (k <= wl) return w[wl - k];
    return 1'b0;
  endfunction

  function automatic bit exp_lr(int p, int dv, int pl, int fr);
    int s;
    s = p / (dv + 1);
    return bit'((fr ^ (s & 1)) ^ pl);
  endfunction

  task automatic do_reset(int wl, int dv, int pl, int fr, int dl);
    @(posedge clk);
    enable = 0; uf_clr = 0; rst_n = 0;
    cfg_wlen = 5'(wl); cfg_div = 8'(dv); cfg_pol = pl[0];
    cfg_first_right = fr[0]; cfg_delay = dl[0];
    @(negedge clk); feed_rst = 1;
    repeat (2) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  task automatic start_feed(int row, int lim);
    @(negedge clk);
    feed_row = row; feed_limit = lim; feed_rst = 0;
    repeat (4) @(posedge clk);
  endtask

  // wlen, div, pol, first_right, delay, mess, slots
  localparam int NROW = 6;
  localparam int TAB [NROW][7] = '{
    '{31, 31, 0, 0, 1, 0, 4},
    '{15, 31, 1, 0, 0, 0, 4},
    '{23, 23, 0, 1, 0, 0, 4},
    '{ 2,  2, 0, 0, 1, 0, 6},
    '{ 7, 12, 1, 1, 1, 1, 5},
    '{ 3,  3, 0, 0, 0, 1, 6}
  };

  initial begin
    rst_n = 0; enable = 0; uf_clr = 0;
    cfg_wlen = 5'd15; cfg_div = 8'd15; cfg_pol = 0; cfg_first_right = 0; cfg_delay = 0;

    // R12: reset state
    do_reset(15, 15, 0, 0, 0);
    chk("R12 sdata after reset", 32'(sdata), 0);
    chk("R12 underflow after reset", 32'(underflow), 0);
    chk("R12 in_ready after reset", 32'(in_ready), 1);
    chk("R2 idle lrclk at left level", 32'(lrclk), 0);
    chk("R9 valid settings no error", 32'(cfg_error), 0);
    // R11: one sample fills the buffer
    start_feed(20, 1);
    chk("R11 ready low when full", 32'(in_ready), 0);

    // table: R1 R2 R3 R4 R5 R6 R10 R11
    for (int r = 0; r < NROW; r++) begin
      int wl, dv, pl, fr, dl, ms, ns;
      wl = TAB[r][0]; dv = TAB[r][1]; pl = TAB[r][2]; fr = TAB[r][3];
      dl = TAB[r][4]; ms = TAB[r][5]; ns = TAB[r][6];
      do_reset(wl, dv, pl, fr, dl);
      start_feed(r, ns + 1);
      @(posedge clk); enable = 1;
      for (int p = 0; p < ns * (dv + 1); p++) begin
        @(posedge clk);
        chk($sformatf("R1/R2/R3 row%0d lrclk p%0d", r, p), 32'(lrclk), 32'(exp_lr(p, dv, pl, fr)));
        chk($sformatf("R4/R5/R6 row%0d sdata p%0d", r, p), 32'(sdata), 32'(exp_sd(p, r, wl, dv, dl)));
        if (p == 0 && ms != 0) begin
          // R10: scramble live settings mid-run
          cfg_wlen = 5'd2; cfg_div = 8'd40; cfg_pol = ~cfg_pol;
          cfg_first_right = ~cfg_first_right; cfg_delay = ~cfg_delay;
        end
      end
      chk($sformatf("R7 row%0d no underflow", r), 32'(underflow), 0);
      @(posedge clk); enable = 0;
      repeat (2) @(posedge clk);
      chk($sformatf("R6 row%0d idle sdata", r), 32'(sdata), 0);
    end

    // R7 / R8: starve after two samples
    do_reset(3, 3, 0, 0, 0);
    start_feed(9, 2);
    @(posedge clk); enable = 1;
    for (int p = 0; p < 16; p++) begin
      logic [31:0] w;
      @(posedge clk);
      w = pat(9, (p / 4) % 2);
      if (p == 7) chk("R7 no underflow before starve", 32'(underflow), 0);
      if (p == 8) chk("R7 underflow at starved slot", 32'(underflow), 1);
      if (p >= 8) chk($sformatf("R7 repeat sample p%0d", p), 32'(sdata), 32'(w[3 - (p % 4)]));
    end
    @(posedge clk); enable = 0;
    repeat (2) @(posedge clk);
    chk("R8 flag sticky while idle", 32'(underflow), 1);
    uf_clr = 1;
    @(posedge clk); uf_clr = 0;
    chk("R8 flag cleared", 32'(underflow), 0);

    // R9: invalid settings
    do_reset(10, 5, 1, 0, 0);
    chk("R9 div below wlen flagged", 32'(cfg_error), 1);
    start_feed(11, 4);
    @(posedge clk); enable = 1;
    for (int p = 0; p < 10; p++) begin
      @(posedge clk);
      chk("R9 no start lrclk", 32'(lrclk), 1);
      chk("R9 no start sdata", 32'(sdata), 0);
    end
    chk("R9 buffer untouched", 32'(in_ready), 0);
    enable = 0; cfg_wlen = 5'd1; cfg_div = 8'd5;
    @(posedge clk);
    chk("R9 wlen below two flagged", 32'(cfg_error), 1);
    cfg_wlen = 5'd5;
    @(posedge clk);
    chk("R9 div equal wlen accepted", 32'(cfg_error), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule